// File: doc/BRIEF.md
# Multi-Rail Power Sequencer with Fault Restart

This block drives the enable lines of a set of regulator rails in a programmed power-up order. When the trigger input is seen high, a shared tick counter starts from zero. Each rail's enable turns on once that count reaches the rail's own turn-on delay. The rail's power-good output follows once a further soft-start interval, also set per rail, has run out. Every rail also has an active-low reset output. That output is released only when the rail is power-good and has no voltage fault present.

The rails are watched for undervoltage and overvoltage faults, and each fault can be masked. An unmasked fault on any rail shuts every rail down together. A fixed off window then follows. When the window ends, the whole sequence starts again from tick zero if the trigger is still high. If the trigger has dropped, the block goes idle. Removing the trigger while the sequence runs turns every rail off at once. All timing is counted in ticks of a prescaled timebase. A simple write port rewrites the delay and ramp settings of a rail, and reset puts them back to their defaults.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, every railEn, railGood and railRstN bit is 0 and restartHold is 0. Rail i's delay returns to i*DEF_DLY_STEP ticks and every ramp returns to DEF_RAMP ticks.
- R2: The trigger is sampled high at a clock edge while idle. Rail i's enable is then high exactly from delay[i]*PRESCALE cycles after that edge, and it stays high while the sequence runs.
- R3: Rail i's railGood is high exactly from (delay[i]+ramp[i])*PRESCALE cycles after the start edge. It is never high while its enable is low.
- R4: railRstN[i] is high only when railGood[i] is high and neither uvFault[i] nor ovFault[i] is high. The mask has no effect on this output.
- R5: Suppose some rail's fault is high with its faultMask bit 0 at an edge while the sequence runs. From that edge on, all enables, power-goods and resets are low and restartHold is high.
- R6: The off window lasts exactly OFF_TICKS*PRESCALE cycles. At its end, if the trigger is high, the sequence restarts at tick zero with the same timing as R2/R3. If the trigger is low, the block goes idle with all outputs low.
- R7: A fault whose faultMask bit is 1 does not shut the rails down, and restartHold stays 0.
- R8: If the trigger is low at an edge while running, all rail outputs are low from that edge on. A later trigger starts the sequence from tick zero.
- R9: When cfgWrEn is high at an edge, cfgData is written to the rail chosen by cfgSel. It goes to the ramp time if cfgIsRamp is 1 and to the delay if it is 0. The next sequence uses the new value.
- R10: Faults while idle are ignored: restartHold stays 0 and no enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Sequence start; level held high to keep rails up |
| cfgWrEn | input | 1 | Setting write strobe |
| cfgSel | input | $clog2(NUM_RAILS) | Rail index of the write |
| cfgIsRamp | input | 1 | 1 writes ramp time, 0 writes turn-on delay |
| cfgData | input | CNT_W | Value written, in ticks |
| uvFault | input | NUM_RAILS | Per-rail undervoltage flag |
| ovFault | input | NUM_RAILS | Per-rail overvoltage flag |
| faultMask | input | NUM_RAILS | 1 stops that rail's faults from causing a restart |
| railEn | output | NUM_RAILS | Regulator enables |
| railGood | output | NUM_RAILS | Per-rail power-good (ramp finished) |
| railRstN | output | NUM_RAILS | Per-rail active-low reset |
| restartHold | output | 1 | High during the post-fault off window |

## Verification
Every rail output is decoded from registered state, so it is due at the first falling edge after the clock edge that sampled the cause. An enable is due delay*PRESCALE edges after the trigger edge, a power-good (delay+ramp)*PRESCALE edges after it, and a shutdown on the very edge that samples the fault. The bench drives inputs and samples outputs only on falling edges. It keeps a count of edges since the sequence start, and the expected vectors are computed from that count. After a fault, the off window is checked cycle by cycle for OFF_TICKS*PRESCALE edges. The restarted sequence is then checked from count zero.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seqState_e;

  // strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic runActive;   // rails may be enabled
    logic clrElapsed;  // restart elapsed-tick count at zero
    logic tickInc;     // one timebase tick passed while running
  } seqStrobe_t;
endpackage

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int PRESCALE  = 4,
  parameter int OFF_TICKS = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigger,
  input  logic [NUM_RAILS-1:0] uvFault,
  input  logic [NUM_RAILS-1:0] ovFault,
  input  logic [NUM_RAILS-1:0] faultMask,
  output seqStrobe_t           strobe,
  output logic                 restartHold
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int OFF_W = $clog2(OFF_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_TICKS - 1);

  seqState_e stateQ, stateD;
  logic [PRE_W-1:0] preCnt;
  logic [OFF_W-1:0] offCnt;
  logic tick;
  logic restartTimer;
  logic tripped;

  assign tick    = (preCnt == PRE_LAST);
  assign tripped = |((uvFault | ovFault) & ~faultMask);

  always_comb begin
    stateD       = stateQ;
    restartTimer = 1'b0;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (trigger) begin
          stateD       = SEQ_RUN;
          restartTimer = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (!trigger) begin
          stateD = SEQ_IDLE;
        end else if (tripped) begin
          stateD       = SEQ_HOLD;
          restartTimer = 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (tick && offCnt == OFF_LAST) begin
          restartTimer = 1'b1;
          stateD       = trigger ? SEQ_RUN : SEQ_IDLE;
        end
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      preCnt <= '0;
      offCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (restartTimer || stateQ == SEQ_IDLE || tick) preCnt <= '0;
      else preCnt <= preCnt + 1'b1;
      if (restartTimer) offCnt <= '0;
      else if (stateQ == SEQ_HOLD && tick) offCnt <= offCnt + 1'b1;
    end
  end

  assign strobe.runActive  = (stateQ == SEQ_RUN);
  assign strobe.clrElapsed = restartTimer;
  assign strobe.tickInc    = (stateQ == SEQ_RUN) && tick;
  assign restartHold       = (stateQ == SEQ_HOLD);
endmodule

// File: rtl/rail_seq_datapath.sv
module rail_seq_datapath
  import rail_seq_pkg::*;
#(
  parameter int NUM_RAILS    = 4,
  parameter int CNT_W        = 6,
  parameter int DEF_DLY_STEP = 3,
  parameter int DEF_RAMP     = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic                         cfgWrEn,
  input  logic [$clog2(NUM_RAILS)-1:0] cfgSel,
  input  logic                         cfgIsRamp,
  input  logic [CNT_W-1:0]             cfgData,
  input  logic [NUM_RAILS-1:0]         uvFault,
  input  logic [NUM_RAILS-1:0]         ovFault,
  output logic [NUM_RAILS-1:0]         railEn,
  output logic [NUM_RAILS-1:0]         railGood,
  output logic [NUM_RAILS-1:0]         railRstN
);
  localparam int SEL_W  = $clog2(NUM_RAILS);
  localparam int ELAP_W = CNT_W + 1;
  localparam logic [ELAP_W-1:0] ELAP_MAX = '1;

  logic [ELAP_W-1:0] elapsed;

  // shared tick count since the current sequence start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) elapsed <= '0;
    else if (strobe.clrElapsed) elapsed <= '0;
    else if (strobe.tickInc && elapsed != ELAP_MAX) elapsed <= elapsed + 1'b1;
  end

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    logic [CNT_W-1:0]  dlyReg;
    logic [CNT_W-1:0]  rampReg;
    logic [ELAP_W-1:0] onMark;
    logic [ELAP_W-1:0] goodMark;
    logic              hit;

    assign hit = cfgWrEn && (cfgSel == SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyReg  <= CNT_W'(g * DEF_DLY_STEP);
        rampReg <= CNT_W'(DEF_RAMP);
      end else if (hit) begin
        if (cfgIsRamp) rampReg <= cfgData;
        else           dlyReg  <= cfgData;
      end
    end

    assign onMark   = {1'b0, dlyReg};
    assign goodMark = {1'b0, dlyReg} + {1'b0, rampReg};

    assign railEn[g]   = strobe.runActive && (elapsed >= onMark);
    assign railGood[g] = strobe.runActive && (elapsed >= goodMark);
    assign railRstN[g] = railGood[g] && !(uvFault[g] || ovFault[g]);
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int NUM_RAILS    = 4,
  parameter int CNT_W        = 6,
  parameter int PRESCALE     = 4,
  parameter int OFF_TICKS    = 25,
  parameter int DEF_DLY_STEP = 3,
  parameter int DEF_RAMP     = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trigger,
  input  logic                         cfgWrEn,
  input  logic [$clog2(NUM_RAILS)-1:0] cfgSel,
  input  logic                         cfgIsRamp,
  input  logic [CNT_W-1:0]             cfgData,
  input  logic [NUM_RAILS-1:0]         uvFault,
  input  logic [NUM_RAILS-1:0]         ovFault,
  input  logic [NUM_RAILS-1:0]         faultMask,
  output logic [NUM_RAILS-1:0]         railEn,
  output logic [NUM_RAILS-1:0]         railGood,
  output logic [NUM_RAILS-1:0]         railRstN,
  output logic                         restartHold
);
  seqStrobe_t strobe;

  rail_seq_ctrl #(
    .NUM_RAILS(NUM_RAILS),
    .PRESCALE (PRESCALE),
    .OFF_TICKS(OFF_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigger    (trigger),
    .uvFault    (uvFault),
    .ovFault    (ovFault),
    .faultMask  (faultMask),
    .strobe     (strobe),
    .restartHold(restartHold)
  );

  rail_seq_datapath #(
    .NUM_RAILS   (NUM_RAILS),
    .CNT_W       (CNT_W),
    .DEF_DLY_STEP(DEF_DLY_STEP),
    .DEF_RAMP    (DEF_RAMP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .cfgIsRamp(cfgIsRamp),
    .cfgData  (cfgData),
    .uvFault  (uvFault),
    .ovFault  (ovFault),
    .railEn   (railEn),
    .railGood (railGood),
    .railRstN (railRstN)
  );
endmodule

// File: rtl/rail_seq_checker.sv
module rail_seq_checker #(
  parameter int NUM_RAILS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trigger,
  input logic [NUM_RAILS-1:0] uvFault,
  input logic [NUM_RAILS-1:0] ovFault,
  input logic [NUM_RAILS-1:0] faultMask,
  input logic [NUM_RAILS-1:0] railEn,
  input logic [NUM_RAILS-1:0] railGood,
  input logic [NUM_RAILS-1:0] railRstN,
  input logic                 restartHold
);
  logic [NUM_RAILS-1:0] liveFault;
  assign liveFault = (uvFault | ovFault) & ~faultMask;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (railEn == '0 && railRstN == '0 && !restartHold));

  p_good_after_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (railGood & ~railEn) == '0);

  p_rst_needs_good_r4: assert property (@(posedge clk) disable iff (!rstN)
    (railRstN & ~(railGood & ~(uvFault | ovFault))) == '0);

  p_fault_shutdown_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|liveFault && |railEn) |=> (railEn == '0 && railGood == '0));

  p_hold_rails_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    restartHold |-> (railEn == '0 && railRstN == '0));

  p_masked_no_trip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|railEn && trigger && liveFault == '0) |=> !restartHold);

  p_trigger_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    !trigger |=> (railEn == '0));
endmodule

bind rail_sequencer rail_seq_checker #(.NUM_RAILS(NUM_RAILS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .trigger    (trigger),
  .uvFault    (uvFault),
  .ovFault    (ovFault),
  .faultMask  (faultMask),
  .railEn     (railEn),
  .railGood   (railGood),
  .railRstN   (railRstN),
  .restartHold(restartHold)
);

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
  localparam int N    = 4;
  localparam int CW   = 6;
  localparam int P    = 4;
  localparam int OFFT = 25;
  localparam int STEP = 3;
  localparam int RMP  = 5;
  localparam int SW   = $clog2(N);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          trigger = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [SW-1:0] cfgSel = '0;
  logic          cfgIsRamp = 1'b0;
  logic [CW-1:0] cfgData = '0;
  logic [N-1:0]  uvFault = '0;
  logic [N-1:0]  ovFault = '0;
  logic [N-1:0]  faultMask = '0;
  logic [N-1:0]  railEn, railGood, railRstN;
  logic          restartHold;

  rail_sequencer #(
    .NUM_RAILS(N), .CNT_W(CW), .PRESCALE(P), .OFF_TICKS(OFFT),
    .DEF_DLY_STEP(STEP), .DEF_RAMP(RMP)
  ) u_rail_sequencer (
    .clk(clk), .rstN(rstN), .trigger(trigger), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgIsRamp(cfgIsRamp), .cfgData(cfgData),
    .uvFault(uvFault), .ovFault(ovFault), .faultMask(faultMask),
    .railEn(railEn), .railGood(railGood), .railRstN(railRstN),
    .restartHold(restartHold)
  );

  int nChk = 0;
  int nFail = 0;
  int seqCyc = 0;
  int bDly[N];
  int bRamp[N];
  bit done = 0;

  function automatic logic [N-1:0] expEn(int c);
    for (int i = 0; i < N; i++) expEn[i] = (c >= bDly[i] * P);
  endfunction

  function automatic logic [N-1:0] expGood(int c);
    for (int i = 0; i < N; i++) expGood[i] = (c >= (bDly[i] + bRamp[i]) * P);
  endfunction

  function automatic int maxSpan();
    maxSpan = 0;
    for (int i = 0; i < N; i++)
      if ((bDly[i] + bRamp[i]) * P > maxSpan) maxSpan = (bDly[i] + bRamp[i]) * P;
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] got, logic [N-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic setDefaults();
    for (int i = 0; i < N; i++) begin
      bDly[i]  = i * STEP;
      bRamp[i] = RMP;
    end
  endtask

  // sample at each falling edge, seqCyc counts edges since the start edge
  task automatic checkRun(string req, int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      chk(req, "railEn", railEn, expEn(seqCyc));
      chk(req, "railGood", railGood, expGood(seqCyc));
      chk(req, "railRstN", railRstN, expGood(seqCyc) & ~(uvFault | ovFault));
      chk(req, "restartHold", {{(N-1){1'b0}}, restartHold}, '0);
      seqCyc++;
    end
  endtask

  task automatic startSeq();
    @(negedge clk);
    trigger = 1'b1;
    seqCyc = 0;
  endtask

  task automatic writeCfg(int rail, bit isRamp, int val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = SW'(rail); cfgIsRamp = isRamp; cfgData = CW'(val);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (isRamp) bRamp[rail] = val; else bDly[rail] = val;
  endtask

  task automatic dropTrigger(string req);
    @(negedge clk);
    trigger = 1'b0;
    @(negedge clk);
    chk(req, "railEn after drop", railEn, '0);
    chk(req, "railRstN after drop", railRstN, '0);
  endtask

  // fault is raised at a falling edge; window checked edge by edge
  task automatic faultWindow(int rail, bit useOv, bit keepTrig);
    if (useOv) ovFault[rail] = 1'b1; else uvFault[rail] = 1'b1;
    for (int j = 0; j < OFFT * P; j++) begin
      @(negedge clk);
      chk("R5", "railEn in hold", railEn, '0);
      chk("R6", "restartHold in hold", {{(N-1){1'b0}}, restartHold}, {{(N-1){1'b0}}, 1'b1});
      if (j == 0) begin uvFault = '0; ovFault = '0; end
      if (j == 3 && !keepTrig) trigger = 1'b0;
    end
    seqCyc = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    setDefaults();
    repeat (3) @(negedge clk);
    chk("R1", "railEn in reset", railEn, '0);
    chk("R1", "railRstN in reset", railRstN, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "restartHold after reset", {{(N-1){1'b0}}, restartHold}, '0);

    // R1 defaults, R2/R3 timing
    startSeq();
    checkRun("R2", maxSpan() + 6);

    // R4 and R7: masked fault keeps rails up, only that reset drops
    faultMask = 4'b0100;
    @(negedge clk);
    uvFault[2] = 1'b1;
    seqCyc++;
    checkRun("R7", 10);
    uvFault = '0;
    faultMask = '0;
    checkRun("R4", 2);

    // R5/R6: unmasked fault, trigger kept, full restart
    faultWindow(1, 1'b1, 1'b1);
    checkRun("R6", maxSpan() + 4);

    // R8: trigger drop, then restart from zero
    dropTrigger("R8");
    startSeq();
    checkRun("R8", maxSpan() + 4);

    // R6: trigger removed during the window ends in idle
    faultWindow(3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6", "idle after window railEn", railEn, '0);
    chk("R6", "idle after window hold", {{(N-1){1'b0}}, restartHold}, '0);

    // R10: faults in idle ignored
    @(negedge clk);
    uvFault = 4'b1111;
    repeat (20) @(negedge clk);
    chk("R10", "hold in idle", {{(N-1){1'b0}}, restartHold}, '0);
    chk("R10", "railEn in idle", railEn, '0);
    uvFault = '0;

    // R9: random settings, random fault events
    for (int it = 0; it < 8; it++) begin
      for (int r = 0; r < N; r++) begin
        writeCfg(r, 1'b0, $urandom_range(0, 15));
        writeCfg(r, 1'b1, $urandom_range(0, 12));
      end
      startSeq();
      checkRun("R9", maxSpan() + 3);
      if (it % 2 == 0) begin
        faultWindow($urandom_range(0, N - 1), it[1], 1'b1);
        checkRun("R9", maxSpan() + 3);
      end
      dropTrigger("R8");
    end

    // R1: reset restores defaults
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    setDefaults();
    startSeq();
    checkRun("R1", maxSpan() + 4);
    dropTrigger("R8");

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule